// File: doc/BRIEF.md
# Width-Adapting Add-On FIFO Port

This block is the local-logic end of two 32-bit FIFOs, one carrying words from the host side to local logic and one carrying words from local logic to the host side. Local logic moves data with plain read and write strobes. The host side is reduced to a push port and a pop port with full and empty flags. The host-bus protocol itself sits outside this block.

A mode input sets the local data bus to 32 or 16 bits. In 16-bit mode an internal half-word phase steers each access. The first access of a pair uses the low half-word of the current entry and the second uses the high half-word. A 2-bit advance selector names the byte lane whose access moves the FIFO pointer. With the advance selector at byte 2 or 3, two 16-bit writes build one entry and two 16-bit reads drain one entry. With the advance selector at byte 0, the pointer moves on every byte-0 access, so the port behaves as an 8-bit FIFO. In 16-bit mode this setting instead splits each pair of half-words across two entries. Two separate active-low clear inputs flush the two directions, and each clear also returns its direction's half-word phase to the low half.

Top module: `wa_fifo_port`

## Requirements
- R1: After reset both FIFOs report empty = 1 and full = 0, and both half-word phases point at the low half.
- R2: With mode16 = 0, a local write with lbe = 4'b1111 stores ldin as a single entry, which the host pop later returns unchanged. A host push is presented whole on ldout, and a local read removes it.
- R3: With mode16 = 1 and adv_sel = 2 or 3, the first write puts ldin[15:0] into bits 15:0 of the current entry without committing it. The second write puts ldin[15:0] into bits 31:16 and commits the entry.
- R4: With mode16 = 1 and adv_sel = 2 or 3, the first read shows bits 15:0 of the head entry on ldout[15:0]. The second read shows bits 31:16 and then removes the entry. ldout[31:16] is zero in 16-bit mode.
- R5: The pointer of the direction being accessed steps only when byte lane adv_sel (0 = bits 7:0 … 3 = bits 31:24) is among the lanes accessed. Writes that miss that lane merge their bytes into the same pending entry.
- R6: With mode16 = 1 and adv_sel = 0, every low-half access steps the pointer. The following high-half write therefore lands in bits 31:16 of the next entry, and the data comes out shifted.
- R7: With mode16 = 0, adv_sel = 0 and lbe = 4'b0001, every write commits one entry holding ldin[7:0] in bits 7:0.
- R8: In 16-bit mode only lbe[1:0] act as byte enables for the current half-word. lbe[3:2] and ldin[31:16] have no effect on stored data or on pointer stepping.
- R9: rd_clr_n low at a clock edge empties the host-to-local FIFO and resets its read phase to the low half. The local-to-host FIFO is unaffected.
- R10: wr_clr_n low at a clock edge empties the local-to-host FIFO and resets its write phase to the low half. The host-to-local FIFO is unaffected.
- R11: Each FIFO holds 8 entries. A write while full and a read while empty are ignored, and neither moves a pointer or a phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode16 | input | 1 | 0: 32-bit local bus, 1: 16-bit local bus |
| adv_sel | input | 2 | Byte lane whose access steps the pointer |
| lbe | input | 4 | Local byte enables, active high |
| lwr | input | 1 | Local write strobe into local-to-host FIFO |
| lrd | input | 1 | Local read strobe from host-to-local FIFO |
| ldin | input | 32 | Local write data |
| ldout | output | 32 | Local read data (head of host-to-local FIFO) |
| rd_clr_n | input | 1 | Active-low flush of host-to-local FIFO |
| wr_clr_n | input | 1 | Active-low flush of local-to-host FIFO |
| h_push | input | 1 | Host push into host-to-local FIFO |
| h_din | input | 32 | Host push data |
| h2l_full | output | 1 | Host-to-local FIFO full |
| h2l_empty | output | 1 | Host-to-local FIFO empty |
| h_pop | input | 1 | Host pop from local-to-host FIFO |
| h_dout | output | 32 | Head of local-to-host FIFO |
| l2h_full | output | 1 | Local-to-host FIFO full |
| l2h_empty | output | 1 | Local-to-host FIFO empty |

## Verification
A half-word phase stuck or inverted shows on the very next 16-bit read as the wrong half on ldout. On the write side, the empty flag either drops one write early or stays high one write late. A pointer that steps on the wrong lane changes the empty flag in the cycle after the access. For writes, it also shows as swapped or shifted words on h_dout at the next pop. A count that misses a blocked write or read appears within eight accesses as a full or empty flag out of step with the number of words pushed. Stale state after a flush shows on the first access that follows, as a non-empty flag or a high-half read.

// File: rtl/wa_pkg.sv
package wa_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned HALF_W = 16;
  localparam int unsigned LANES  = WORD_W / 8;

  // Byte lanes touched by one local access, given the bus mode and phase.
  function automatic logic [LANES-1:0] lanes_hit(input logic m16,
                                                 input logic phase,
                                                 input logic [LANES-1:0] be);
    logic [LANES-1:0] r;
    if (!m16)      r = be;
    else if (phase) r = {be[1:0], 2'b00};
    else            r = {2'b00, be[1:0]};
    return r;
  endfunction

  // True when the selected advance lane is among the touched lanes.
  function automatic logic lane_steps(input logic [LANES-1:0] lanes,
                                      input logic [1:0] sel);
    return lanes[sel];
  endfunction

  // Next pointer value with wrap at depth.
  function automatic int unsigned ptr_next(input int unsigned p,
                                           input int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/wa_fifo_core.sv
module wa_fifo_core #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            wr_en,
  input  logic [DW/8-1:0] wr_be,
  input  logic [DW-1:0]   wr_data,
  input  logic            wr_step,
  input  logic            rd_step,
  output logic [DW-1:0]   rd_data,
  output logic            full,
  output logic            empty
);
  localparam int unsigned NL = DW / 8;
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = PW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;

  // named internal events
  logic wr_ok, wr_adv, rd_ok;
  assign wr_ok  = wr_en & ~full & ~clr;
  assign wr_adv = wr_ok & wr_step;
  assign rd_ok  = rd_step & ~empty & ~clr;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign rd_data = mem[rptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < DEPTH; e++) mem[e] <= '0;
    end else if (wr_ok) begin
      for (int l = 0; l < NL; l++)
        if (wr_be[l]) mem[wptr][l*8 +: 8] <= wr_data[l*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else if (clr) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (wr_adv) wptr <= PW'(wa_pkg::ptr_next(32'(wptr), DEPTH));
      if (rd_ok)  rptr <= PW'(wa_pkg::ptr_next(32'(rptr), DEPTH));
      cnt <= cnt + CW'(wr_adv) - CW'(rd_ok);
    end
  end

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  assert_flags_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
  // flush of either direction (R9, R10)
  assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> empty);
  assert_full_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rd_step && !clr) |=> (full && $stable(wptr)));
  assert_empty_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !(wr_en && wr_step) && !clr) |=> (empty && $stable(rptr)));
endmodule

// File: rtl/wa_wr_steer.sv
module wa_wr_steer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        mode16,
  input  logic [1:0]  adv_sel,
  input  logic [3:0]  lbe,
  input  logic        lwr,
  input  logic [31:0] ldin,
  input  logic        full,
  output logic        wr_en,
  output logic [3:0]  wr_be,
  output logic [31:0] wr_data,
  output logic        wr_step
);
  logic phase;
  logic [3:0] lanes;
  logic accepted;

  assign lanes    = wa_pkg::lanes_hit(mode16, phase, lbe);
  assign wr_en    = lwr;
  assign wr_be    = lanes;
  assign wr_data  = mode16 ? {ldin[15:0], ldin[15:0]} : ldin;
  assign wr_step  = lwr & wa_pkg::lane_steps(lanes, adv_sel);
  assign accepted = lwr & ~full & ~clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                phase <= 1'b0;
    else if (clr || !mode16)   phase <= 1'b0;
    else if (accepted)         phase <= ~phase;
  end

  assert_phase_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !phase);
  assert_low_half_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode16 && adv_sel[1] && !phase) |-> !wr_step);
  assert_full_keeps_phase_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !clr && mode16) |=> $stable(phase) || !mode16);
endmodule

// File: rtl/wa_rd_steer.sv
module wa_rd_steer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        mode16,
  input  logic [1:0]  adv_sel,
  input  logic [3:0]  lbe,
  input  logic        lrd,
  input  logic [31:0] entry,
  input  logic        empty,
  output logic [31:0] ldout,
  output logic        rd_step
);
  logic phase;
  logic [3:0] lanes;
  logic accepted;

  assign lanes    = wa_pkg::lanes_hit(mode16, phase, lbe);
  assign rd_step  = lrd & wa_pkg::lane_steps(lanes, adv_sel);
  assign accepted = lrd & ~empty & ~clr;
  assign ldout    = !mode16 ? entry
                  : {16'h0000, (phase ? entry[31:16] : entry[15:0])};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                phase <= 1'b0;
    else if (clr || !mode16)   phase <= 1'b0;
    else if (accepted)         phase <= ~phase;
  end

  assert_phase_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !phase);
  assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mode16 |-> (ldout[31:16] == 16'h0000));
  assert_empty_keeps_phase_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && lrd && mode16 && !clr) |=> ($stable(phase) || !mode16));
endmodule

// File: rtl/wa_fifo_port.sv
module wa_fifo_port #(
  parameter int unsigned DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode16,
  input  logic [1:0]  adv_sel,
  input  logic [3:0]  lbe,
  input  logic        lwr,
  input  logic        lrd,
  input  logic [31:0] ldin,
  output logic [31:0] ldout,
  input  logic        rd_clr_n,
  input  logic        wr_clr_n,
  input  logic        h_push,
  input  logic [31:0] h_din,
  output logic        h2l_full,
  output logic        h2l_empty,
  input  logic        h_pop,
  output logic [31:0] h_dout,
  output logic        l2h_full,
  output logic        l2h_empty
);
  localparam int unsigned W  = wa_pkg::WORD_W;
  localparam int unsigned NL = wa_pkg::LANES;

  // named internal events
  logic h2l_clr, l2h_clr;
  logic h2l_rd_step;
  logic [W-1:0] h2l_head;
  logic l2h_wr_en, l2h_wr_step;
  logic [NL-1:0] l2h_wr_be;
  logic [W-1:0] l2h_wr_data;

  assign h2l_clr = ~rd_clr_n;
  assign l2h_clr = ~wr_clr_n;

  wa_fifo_core #(.DW(W), .DEPTH(DEPTH)) u_h2l (
    .clk(clk), .rst_n(rst_n), .clr(h2l_clr),
    .wr_en(h_push), .wr_be({NL{1'b1}}), .wr_data(h_din), .wr_step(1'b1),
    .rd_step(h2l_rd_step), .rd_data(h2l_head),
    .full(h2l_full), .empty(h2l_empty)
  );

  wa_rd_steer u_rd (
    .clk(clk), .rst_n(rst_n), .clr(h2l_clr), .mode16(mode16),
    .adv_sel(adv_sel), .lbe(lbe), .lrd(lrd), .entry(h2l_head),
    .empty(h2l_empty), .ldout(ldout), .rd_step(h2l_rd_step)
  );

  wa_wr_steer u_wr (
    .clk(clk), .rst_n(rst_n), .clr(l2h_clr), .mode16(mode16),
    .adv_sel(adv_sel), .lbe(lbe), .lwr(lwr), .ldin(ldin), .full(l2h_full),
    .wr_en(l2h_wr_en), .wr_be(l2h_wr_be), .wr_data(l2h_wr_data),
    .wr_step(l2h_wr_step)
  );

  wa_fifo_core #(.DW(W), .DEPTH(DEPTH)) u_l2h (
    .clk(clk), .rst_n(rst_n), .clr(l2h_clr),
    .wr_en(l2h_wr_en), .wr_be(l2h_wr_be), .wr_data(l2h_wr_data),
    .wr_step(l2h_wr_step), .rd_step(h_pop), .rd_data(h_dout),
    .full(l2h_full), .empty(l2h_empty)
  );

  // one direction's flush leaves the other's flags alone
  assert_flush_isolated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (h2l_clr && !l2h_clr && !lwr && !h_pop) |=> $stable(l2h_empty));
  assert_flush_isolated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (l2h_clr && !h2l_clr && !lrd && !h_push) |=> $stable(h2l_empty));
endmodule

// File: tb/tb_wa_fifo_port.sv
`timescale 1ns/1ps
module tb_wa_fifo_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode16 = 1'b0;
  logic [1:0] adv_sel = 2'd0;
  logic [3:0] lbe = 4'h0;
  logic lwr = 1'b0, lrd = 1'b0;
  logic [31:0] ldin = '0;
  logic [31:0] ldout;
  logic rd_clr_n = 1'b1, wr_clr_n = 1'b1;
  logic h_push = 1'b0;
  logic [31:0] h_din = '0;
  logic h2l_full, h2l_empty;
  logic h_pop = 1'b0;
  logic [31:0] h_dout;
  logic l2h_full, l2h_empty;

  int total = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wa_fifo_port dut (
    .clk(clk), .rst_n(rst_n), .mode16(mode16), .adv_sel(adv_sel), .lbe(lbe),
    .lwr(lwr), .lrd(lrd), .ldin(ldin), .ldout(ldout),
    .rd_clr_n(rd_clr_n), .wr_clr_n(wr_clr_n),
    .h_push(h_push), .h_din(h_din), .h2l_full(h2l_full), .h2l_empty(h2l_empty),
    .h_pop(h_pop), .h_dout(h_dout), .l2h_full(l2h_full), .l2h_empty(l2h_empty)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic lw(input logic [31:0] d, input logic [3:0] be);
    @(negedge clk); lwr = 1'b1; ldin = d; lbe = be;
    @(negedge clk); lwr = 1'b0; lbe = 4'h0;
  endtask

  task automatic lr_chk(input string req, input logic [31:0] exp, input logic [3:0] be);
    @(negedge clk); chk(req, ldout, exp); lrd = 1'b1; lbe = be;
    @(negedge clk); lrd = 1'b0; lbe = 4'h0;
  endtask

  task automatic hpush(input logic [31:0] d);
    @(negedge clk); h_push = 1'b1; h_din = d;
    @(negedge clk); h_push = 1'b0;
  endtask

  task automatic hpop_chk(input string req, input logic [31:0] exp);
    @(negedge clk); chk(req, h_dout, exp); h_pop = 1'b1;
    @(negedge clk); h_pop = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 h2l_empty", 32'(h2l_empty), 32'd1);
    chk("R1 l2h_empty", 32'(l2h_empty), 32'd1);
    chk("R1 h2l_full", 32'(h2l_full), 32'd0);
    chk("R1 l2h_full", 32'(l2h_full), 32'd0);
  endtask

  task automatic t_word32();
    mode16 = 0; adv_sel = 0;
    lw(32'hA5A5_1234, 4'hF);
    chk("R2 l2h not empty", 32'(l2h_empty), 32'd0);
    hpop_chk("R2 host pop", 32'hA5A5_1234);
    hpush(32'hCAFE_BABE);
    lr_chk("R2 local read", 32'hCAFE_BABE, 4'hF);
    chk("R2 h2l drained", 32'(h2l_empty), 32'd1);
  endtask

  task automatic t_lane_select();
    mode16 = 0; adv_sel = 3;
    lw(32'h0000_00AA, 4'b0001);
    chk("R5 no step lane0", 32'(l2h_empty), 32'd1);
    lw(32'h0000_BB00, 4'b0010);
    lw(32'h00DD_0000, 4'b0100);
    chk("R5 no step lane2", 32'(l2h_empty), 32'd1);
    lw(32'hCC00_0000, 4'b1000);
    chk("R5 step lane3", 32'(l2h_empty), 32'd0);
    hpop_chk("R5 merged entry", 32'hCCDD_BBAA);
  endtask

  task automatic t_pack16();
    mode16 = 1; adv_sel = 2;
    lw(32'h0000_1111, 4'b0011);
    chk("R3 first half pending", 32'(l2h_empty), 32'd1);
    lw(32'h0000_2222, 4'b0011);
    chk("R3 committed", 32'(l2h_empty), 32'd0);
    hpop_chk("R3 packed word", 32'h2222_1111);
  endtask

  task automatic t_unpack16();
    mode16 = 1; adv_sel = 3;
    hpush(32'hBEEF_F00D);
    lr_chk("R4 low half", 32'h0000_F00D, 4'b0011);
    chk("R4 entry kept", 32'(h2l_empty), 32'd0);
    lr_chk("R4 high half", 32'h0000_BEEF, 4'b0011);
    chk("R4 entry drained", 32'(h2l_empty), 32'd1);
  endtask

  task automatic t_shift();
    mode16 = 1; adv_sel = 0;
    lw(32'h0000_3333, 4'b0011);
    chk("R6 step after low", 32'(l2h_empty), 32'd0);
    lw(32'h0000_4444, 4'b0011);
    lw(32'h0000_5555, 4'b0011);
    hpop_chk("R6 first entry low only", 32'h0000_3333);
    hpop_chk("R6 shifted entry", 32'h4444_5555);
    chk("R6 drained", 32'(l2h_empty), 32'd1);
  endtask

  task automatic t_byte8();
    mode16 = 0; adv_sel = 0;
    lw(32'h0000_0077, 4'b0001);
    lw(32'h0000_0088, 4'b0001);
    hpop_chk("R7 byte entry 1", 32'h0000_0077);
    hpop_chk("R7 byte entry 2", 32'h0000_0088);
    chk("R7 drained", 32'(l2h_empty), 32'd1);
  endtask

  task automatic t_ignore_upper();
    mode16 = 1; adv_sel = 2;
    lw(32'hFFFF_1234, 4'b1111);
    chk("R8 lbe[3:2] no step", 32'(l2h_empty), 32'd1);
    lw(32'hEEEE_5678, 4'b0011);
    hpop_chk("R8 upper ignored", 32'h5678_1234);
  endtask

  task automatic t_full_empty();
    mode16 = 0; adv_sel = 0;
    for (int i = 0; i < 8; i++) lw(32'h100 + 32'(i), 4'hF);
    chk("R11 l2h full", 32'(l2h_full), 32'd1);
    lw(32'hDEAD_DEAD, 4'hF);
    for (int i = 0; i < 8; i++) hpop_chk("R11 l2h order", 32'h100 + 32'(i));
    chk("R11 l2h empty", 32'(l2h_empty), 32'd1);
    @(negedge clk); h_pop = 1'b1; @(negedge clk); h_pop = 1'b0;
    chk("R11 pop on empty", 32'(l2h_empty), 32'd1);
    lw(32'h0000_0055, 4'hF);
    hpop_chk("R11 after blocked ops", 32'h0000_0055);
    for (int i = 0; i < 9; i++) hpush(32'h200 + 32'(i));
    chk("R11 h2l full", 32'(h2l_full), 32'd1);
    for (int i = 0; i < 8; i++) lr_chk("R11 h2l order", 32'h200 + 32'(i), 4'hF);
    chk("R11 h2l empty", 32'(h2l_empty), 32'd1);
    mode16 = 1; adv_sel = 2;
    @(negedge clk); lrd = 1'b1; lbe = 4'b0011; @(negedge clk); lrd = 1'b0; lbe = 0;
    hpush(32'h1234_ABCD);
    lr_chk("R11 read on empty kept phase", 32'h0000_ABCD, 4'b0011);
    lr_chk("R11 second half", 32'h0000_1234, 4'b0011);
  endtask

  task automatic t_rd_clear();
    mode16 = 0; adv_sel = 0;
    lw(32'h1357_2468, 4'hF);
    mode16 = 1; adv_sel = 2;
    hpush(32'h0A0B_0C0D);
    hpush(32'h1111_2222);
    lr_chk("R9 low before flush", 32'h0000_0C0D, 4'b0011);
    @(negedge clk); rd_clr_n = 1'b0; @(negedge clk); rd_clr_n = 1'b1;
    chk("R9 h2l flushed", 32'(h2l_empty), 32'd1);
    chk("R9 l2h untouched", 32'(l2h_empty), 32'd0);
    hpush(32'h7777_6666);
    lr_chk("R9 phase back to low", 32'h0000_6666, 4'b0011);
    lr_chk("R9 high after flush", 32'h0000_7777, 4'b0011);
    hpop_chk("R9 l2h data kept", 32'h1357_2468);
  endtask

  task automatic t_wr_clear();
    mode16 = 1; adv_sel = 2;
    hpush(32'h0BAD_F00D);
    lw(32'h0000_AAAA, 4'b0011);
    @(negedge clk); wr_clr_n = 1'b0; @(negedge clk); wr_clr_n = 1'b1;
    chk("R10 l2h flushed", 32'(l2h_empty), 32'd1);
    chk("R10 h2l untouched", 32'(h2l_empty), 32'd0);
    lw(32'h0000_BBBB, 4'b0011);
    chk("R10 low half pending", 32'(l2h_empty), 32'd1);
    lw(32'h0000_CCCC, 4'b0011);
    hpop_chk("R10 phase back to low", 32'hCCCC_BBBB);
    lr_chk("R10 h2l low", 32'h0000_F00D, 4'b0011);
    lr_chk("R10 h2l high", 32'h0000_0BAD, 4'b0011);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_word32();
    t_lane_select();
    t_pack16();
    t_unpack16();
    t_shift();
    t_byte8();
    t_ignore_upper();
    t_full_empty();
    t_rd_clear();
    t_wr_clear();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule